// File: doc/BRIEF.md
# Transmit Queue Frame Finalizer

This block empties a short queue of packet numbers that are waiting to go out on the wire. Each number selects one buffer in an internal byte memory. Before anything is sent, the block stamps a fixed status pattern into the first two bytes of the selected buffer. It then reads the 16-bit byte count kept in the buffer header. The payload length comes from that count, less a fixed header and trailer overhead, plus one byte when the trailing control byte marks an odd final byte. Short frames can be zero-padded to a minimum size. The payload goes out one byte per cycle on a valid/ready stream, and the last byte of each frame is flagged.

When a frame is finished, the buffer is either handed back at once through a release pulse, or its packet number is logged in a completion queue that the surrounding logic pops later. Once the whole queue has been drained, a single-cycle done pulse is raised so that the owner can update its interrupt state. A host port writes and reads the buffer memory, and queue entries are pushed through a separate port.

Top module: `txf_finalizer`

## Requirements
- R1: No frame starts while `tx_en` is low or while the transmit queue is empty. Entries stay queued until `tx_en` is high.
- R2: For each frame sent, byte 0 of its buffer becomes 0x01 and byte 1 becomes 0x40. Both can be read back through the host read port.
- R3: The byte count is stored with its low byte at buffer byte 2 and its high byte at byte 3. The base payload length is count - 6, and the payload is streamed in order starting at buffer byte 4.
- R4: The control byte sits at buffer byte count - 1. When its bit 5 is set, the payload length grows by one. No other bit of it changes the length.
- R5: With `pad_en` high and a payload length below 64, the frame is extended to exactly 64 bytes, and every byte past the payload is 0x00. In all other cases the frame is not padded.
- R6: `out_last` is high on the final byte of each frame and on no other byte. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R7: With `auto_rel` high, each finished frame gives a one-cycle `rel_valid` pulse carrying its packet number on `rel_pkt`, and the completion queue is left untouched.
- R8: With `auto_rel` low, each finished packet number is appended to the completion queue unless that queue already holds NUM_BUF entries, in which case the number is dropped. `cq_head` shows the oldest entry, `cq_count` shows the number of entries, and `cq_pop` removes the head.
- R9: Packets are sent in push order. When the queue has been drained, `done` is high for exactly one cycle and the queue is empty.
- R10: The transmit queue holds NUM_BUF entries. A push made while the queue is full, or while a drain is in progress, is dropped.
- R11: A frame whose final length is zero sends no bytes but is still released or logged like any other frame, and it still counts toward the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable, sampled when a drain starts |
| pad_en | input | 1 | Pad short frames to 64 bytes |
| auto_rel | input | 1 | Release buffers instead of logging them |
| q_push | input | 1 | Push a packet number into the transmit queue |
| q_pkt | input | PW | Packet number to push |
| host_we | input | 1 | Host buffer write strobe |
| host_pkt | input | PW | Host write buffer select |
| host_addr | input | AW | Host write byte address |
| host_wdata | input | 8 | Host write data |
| host_rd_pkt | input | PW | Host read buffer select |
| host_rd_addr | input | AW | Host read byte address |
| host_rd_data | output | 8 | Host read data (combinational) |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of frame |
| rel_valid | output | 1 | Buffer release pulse |
| rel_pkt | output | PW | Released packet number |
| cq_pop | input | 1 | Remove the completion queue head |
| cq_head | output | PW | Oldest completion entry |
| cq_count | output | CW | Completion queue occupancy |
| done | output | 1 | One-cycle pulse after the queue is drained |

## Verification
The in-line assertions rely on two things about the environment. The host must not write the buffer memory while a drain is in progress, because the held-data check assumes that the byte under the read pointer does not change. `pad_en` and `auto_rel` must also stay steady for the whole drain. The bench loads buffers and pushes entries only while the block is idle. It changes the configuration only between drains, and it makes its one push during a drain only to show that such a push is dropped. Stored counts always lie between 6 and the buffer size, so every address the block forms stays inside its own buffer.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef logic [15:0] len_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAT0,
        ST_STAT1,
        ST_CNTLO,
        ST_CNTHI,
        ST_CTRL,
        ST_SEND,
        ST_FIN,
        ST_PICK
    } eng_state_e;

    localparam logic [7:0] STATUS_LO     = 8'h01;
    localparam logic [7:0] STATUS_HI     = 8'h40;
    localparam len_t       HDR_OVERHEAD  = 16'd6;
    localparam len_t       PAD_TARGET    = 16'd64;
    localparam len_t       PAYLOAD_BASE  = 16'd4;
    localparam int         ODD_FLAG_BIT  = 5;
    localparam int         CNT_LO_OFF    = 2;
    localparam int         CNT_HI_OFF    = 3;

    typedef struct packed {
        len_t data_len;   // bytes taken from the buffer
        len_t frame_len;  // bytes on the wire after padding
    } frame_len_t;

    function automatic frame_len_t calc_frame(len_t cnt, logic [7:0] ctrl, logic pad);
        frame_len_t f;
        f.data_len  = cnt - HDR_OVERHEAD + {15'd0, ctrl[ODD_FLAG_BIT]};
        f.frame_len = (pad && (f.data_len < PAD_TARGET)) ? PAD_TARGET : f.data_len;
        return f;
    endfunction

endpackage

// File: rtl/txf_bufmem.sv
module txf_bufmem #(
    parameter int NUM_BUF   = 4,
    parameter int BUF_BYTES = 256,
    localparam int PW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int AW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [PW-1:0] a_pkt,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    input  logic          b_we,
    input  logic [PW-1:0] b_pkt,
    input  logic [AW-1:0] b_addr,
    input  logic [7:0]    b_wdata,
    input  logic [PW-1:0] r0_pkt,
    input  logic [AW-1:0] r0_addr,
    output logic [7:0]    r0_data,
    input  logic [PW-1:0] r1_pkt,
    input  logic [AW-1:0] r1_addr,
    output logic [7:0]    r1_data
);
    localparam int DEPTH = 2 ** (PW + AW);

    logic [7:0] store [DEPTH];

    // engine port b wins over host port a on a collision
    always_ff @(posedge clk) begin
        if (b_we)
            store[{b_pkt, b_addr}] <= b_wdata;
        else if (a_we)
            store[{a_pkt, a_addr}] <= a_wdata;
    end

    assign r0_data = store[{r0_pkt, r0_addr}];
    assign r1_data = store[{r1_pkt, r1_addr}];

endmodule

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]    slots [DEPTH];
    logic [PTRW-1:0] rd_p, wr_p;
    logic [CW-1:0]   cnt;
    logic            full, empty, do_push, do_pop;

    function automatic logic [PTRW-1:0] step(logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push)
            slots[wr_p] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wr_p <= step(wr_p);
            if (do_pop)  rd_p <= step(rd_p);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = slots[rd_p];
    assign count = cnt;

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R8
    fifo_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/txf_engine.sv
module txf_engine
    import txf_pkg::*;
#(
    parameter int NUM_BUF   = 4,
    parameter int BUF_BYTES = 256,
    localparam int PW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int AW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_en,
    input  logic          pad_en,
    input  logic          auto_rel,
    input  logic [PW-1:0] q_head,
    input  logic          q_empty,
    output logic          q_pop,
    output logic [PW-1:0] mem_pkt,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_wr_addr,
    output logic [7:0]    mem_wr_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          rel_valid,
    output logic [PW-1:0] rel_pkt,
    output logic          cq_push,
    output logic [PW-1:0] cq_pkt,
    output logic          busy,
    output logic          done
);
    eng_state_e st;
    logic [PW-1:0] pkt_r;
    len_t          cnt_r;
    len_t          idx_r;
    frame_len_t    fl_r, fl_next;
    logic          done_r;
    logic          sending, at_end;

    assign fl_next = calc_frame(cnt_r, mem_rd_data, pad_en);

    // read address follows the phase of the frame
    always_comb begin
        case (st)
            ST_CNTLO: mem_rd_addr = AW'(CNT_LO_OFF);
            ST_CNTHI: mem_rd_addr = AW'(CNT_HI_OFF);
            ST_CTRL:  mem_rd_addr = AW'(cnt_r - 16'd1);
            default:  mem_rd_addr = AW'(idx_r + PAYLOAD_BASE);
        endcase
    end

    assign mem_pkt     = pkt_r;
    assign mem_we      = (st == ST_STAT0) || (st == ST_STAT1);
    assign mem_wr_addr = (st == ST_STAT1) ? AW'(1) : AW'(0);
    assign mem_wr_data = (st == ST_STAT1) ? STATUS_HI : STATUS_LO;

    assign sending   = (st == ST_SEND);
    assign at_end    = (idx_r == fl_r.frame_len - 16'd1);
    assign out_valid = sending;
    assign out_data  = (sending && (idx_r < fl_r.data_len)) ? mem_rd_data : 8'h00;
    assign out_last  = sending && at_end;

    assign rel_valid = (st == ST_FIN) && auto_rel;
    assign rel_pkt   = pkt_r;
    assign cq_push   = (st == ST_FIN) && !auto_rel;
    assign cq_pkt    = pkt_r;
    assign q_pop     = (st == ST_FIN);
    assign busy      = (st != ST_IDLE);
    assign done      = done_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pkt_r  <= '0;
            cnt_r  <= '0;
            idx_r  <= '0;
            fl_r   <= '0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (tx_en && !q_empty) begin
                        pkt_r <= q_head;
                        st    <= ST_STAT0;
                    end
                end
                ST_STAT0: st <= ST_STAT1;
                ST_STAT1: st <= ST_CNTLO;
                ST_CNTLO: begin
                    cnt_r[7:0] <= mem_rd_data;
                    st         <= ST_CNTHI;
                end
                ST_CNTHI: begin
                    cnt_r[15:8] <= mem_rd_data;
                    st          <= ST_CTRL;
                end
                ST_CTRL: begin
                    fl_r  <= fl_next;
                    idx_r <= '0;
                    st    <= (fl_next.frame_len == '0) ? ST_FIN : ST_SEND;
                end
                ST_SEND: begin
                    if (out_ready) begin
                        idx_r <= idx_r + 16'd1;
                        if (at_end) st <= ST_FIN;
                    end
                end
                ST_FIN: st <= ST_PICK;
                ST_PICK: begin
                    if (!q_empty) begin
                        pkt_r <= q_head;
                        st    <= ST_STAT0;
                    end else begin
                        done_r <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    rel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> (!cq_push && !out_valid));

endmodule

// File: rtl/txf_finalizer.sv
module txf_finalizer
    import txf_pkg::*;
#(
    parameter int NUM_BUF   = 4,
    parameter int BUF_BYTES = 256,
    localparam int PW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int CW = $clog2(NUM_BUF + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_en,
    input  logic          pad_en,
    input  logic          auto_rel,
    input  logic          q_push,
    input  logic [PW-1:0] q_pkt,
    input  logic          host_we,
    input  logic [PW-1:0] host_pkt,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    input  logic [PW-1:0] host_rd_pkt,
    input  logic [AW-1:0] host_rd_addr,
    output logic [7:0]    host_rd_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          rel_valid,
    output logic [PW-1:0] rel_pkt,
    input  logic          cq_pop,
    output logic [PW-1:0] cq_head,
    output logic [CW-1:0] cq_count,
    output logic          done
);
    logic [PW-1:0] q_head, e_pkt, cq_pkt;
    logic [CW-1:0] q_count;
    logic          q_empty, q_pop, busy, cq_push;
    logic [AW-1:0] e_rd_addr, e_wr_addr;
    logic [7:0]    e_rd_data, e_wr_data;
    logic          e_we;

    assign q_empty = (q_count == '0);

    txf_fifo #(.DEPTH(NUM_BUF), .W(PW)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push && !busy),
        .din   (q_pkt),
        .pop   (q_pop),
        .dout  (q_head),
        .count (q_count)
    );

    txf_fifo #(.DEPTH(NUM_BUF), .W(PW)) u_cq (
        .clk   (clk),
        .rst   (rst),
        .push  (cq_push),
        .din   (cq_pkt),
        .pop   (cq_pop),
        .dout  (cq_head),
        .count (cq_count)
    );

    txf_bufmem #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_mem (
        .clk     (clk),
        .a_we    (host_we),
        .a_pkt   (host_pkt),
        .a_addr  (host_addr),
        .a_wdata (host_wdata),
        .b_we    (e_we),
        .b_pkt   (e_pkt),
        .b_addr  (e_wr_addr),
        .b_wdata (e_wr_data),
        .r0_pkt  (e_pkt),
        .r0_addr (e_rd_addr),
        .r0_data (e_rd_data),
        .r1_pkt  (host_rd_pkt),
        .r1_addr (host_rd_addr),
        .r1_data (host_rd_data)
    );

    txf_engine #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .tx_en       (tx_en),
        .pad_en      (pad_en),
        .auto_rel    (auto_rel),
        .q_head      (q_head),
        .q_empty     (q_empty),
        .q_pop       (q_pop),
        .mem_pkt     (e_pkt),
        .mem_rd_addr (e_rd_addr),
        .mem_rd_data (e_rd_data),
        .mem_we      (e_we),
        .mem_wr_addr (e_wr_addr),
        .mem_wr_data (e_wr_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data),
        .out_last    (out_last),
        .rel_valid   (rel_valid),
        .rel_pkt     (rel_pkt),
        .cq_push     (cq_push),
        .cq_pkt      (cq_pkt),
        .busy        (busy),
        .done        (done)
    );

    // R9
    q_drained_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (q_count == '0));

endmodule

// File: tb/tb_txf_finalizer.sv
module tb_txf_finalizer;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int BB = 256;

    logic clk, rst, tx_en, pad_en, auto_rel, q_push, host_we, out_ready, cq_pop;
    logic [1:0] q_pkt, host_pkt, host_rd_pkt, rel_pkt, cq_head;
    logic [7:0] host_addr, host_wdata, host_rd_addr, host_rd_data, out_data;
    logic [2:0] cq_count;
    logic out_valid, out_last, rel_valid, done;

    txf_finalizer #(.NUM_BUF(NB), .BUF_BYTES(BB)) dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .pad_en(pad_en), .auto_rel(auto_rel),
        .q_push(q_push), .q_pkt(q_pkt), .host_we(host_we), .host_pkt(host_pkt),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rd_pkt(host_rd_pkt),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .rel_valid(rel_valid), .rel_pkt(rel_pkt),
        .cq_pop(cq_pop), .cq_head(cq_head), .cq_count(cq_count), .done(done)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit ready_rand = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0] sh [NB][BB];
    int got_d[$], got_l[$], got_rel[$];
    int exp_d[$], exp_l[$], exp_rel[$], exp_cq[$];
    int done_seen = 0;
    int stalls = 0;
    bit prev_stall = 0;
    logic [7:0] prev_data;
    logic prev_last;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sink ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // monitor samples at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                stalls++;
                if (!out_valid || out_data !== prev_data || out_last !== prev_last)
                    chk("R6 hold under backpressure", 1, 0);
            end
            if (out_valid && out_ready) begin
                got_d.push_back(int'(out_data));
                got_l.push_back(int'(out_last));
            end
            if (rel_valid) got_rel.push_back(int'(rel_pkt));
            if (done) done_seen++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int p, int a, int d);
        host_we = 1'b1; host_pkt = 2'(p); host_addr = 8'(a); host_wdata = 8'(d);
        tick();
        host_we = 1'b0;
        sh[p][a] = 8'(d);
    endtask

    task automatic load(int p, int cnt, int ctrl);
        wr(p, 2, cnt & 255);
        wr(p, 3, cnt >> 8);
        for (int i = 4; i <= cnt - 2; i++) wr(p, i, (p * 37 + i * 5 + 1) & 255);
        wr(p, cnt - 1, ctrl);
    endtask

    task automatic push(int p);
        q_push = 1'b1; q_pkt = 2'(p);
        tick();
        q_push = 1'b0;
    endtask

    // expected frame from the requirements (R3 R4 R5 R7 R8)
    task automatic add_exp(int p, bit pad, bit autor);
        int cnt, ctrl, dl, fl;
        cnt  = int'(sh[p][2]) + 256 * int'(sh[p][3]);
        ctrl = int'(sh[p][cnt - 1]);
        dl   = cnt - 6 + ((ctrl >> 5) & 1);
        fl   = (pad && dl < 64) ? 64 : dl;
        for (int i = 0; i < fl; i++) begin
            exp_d.push_back(i < dl ? int'(sh[p][4 + i]) : 0);
            exp_l.push_back(i == fl - 1 ? 1 : 0);
        end
        if (autor) exp_rel.push_back(p);
        else if (exp_cq.size() < NB) exp_cq.push_back(p);
    endtask

    task automatic drain(string req);
        int n, dm, lm, rm;
        n = 0;
        while (done_seen == 0 && n < 5000) begin
            tick();
            n++;
        end
        repeat (4) tick();
        chk({req, " byte count"}, got_d.size(), exp_d.size());
        dm = 0; lm = 0; rm = 0;
        for (int i = 0; i < got_d.size() && i < exp_d.size(); i++) begin
            if (got_d[i] != exp_d[i]) dm++;
            if (got_l[i] != exp_l[i]) lm++;
        end
        chk({req, " data mismatches"}, dm, 0);
        chk({req, " R6 last flag mismatches"}, lm, 0);
        chk({req, " R7 release count"}, got_rel.size(), exp_rel.size());
        for (int i = 0; i < got_rel.size() && i < exp_rel.size(); i++)
            if (got_rel[i] != exp_rel[i]) rm++;
        chk({req, " R7 release order"}, rm, 0);
        chk({req, " R9 done pulses"}, done_seen, 1);
        got_d.delete(); got_l.delete(); got_rel.delete();
        exp_d.delete(); exp_l.delete(); exp_rel.delete();
        done_seen = 0;
    endtask

    task automatic check_cq(string req);
        chk({req, " cq_count"}, int'(cq_count), exp_cq.size());
        while (exp_cq.size() > 0) begin
            chk({req, " cq_head"}, int'(cq_head), exp_cq[0]);
            void'(exp_cq.pop_front());
            cq_pop = 1'b1;
            tick();
            cq_pop = 1'b0;
        end
        chk({req, " cq empty after pops"}, int'(cq_count), 0);
    endtask

    task automatic check_status(int p);
        host_rd_pkt = 2'(p);
        host_rd_addr = 8'd0;
        #1;
        chk("R2 status byte 0", int'(host_rd_data), 1);
        host_rd_addr = 8'd1;
        #1;
        chk("R2 status byte 1", int'(host_rd_data), 64);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tx_en = 1'b0; pad_en = 1'b0; auto_rel = 1'b0;
        q_push = 1'b0; q_pkt = '0; host_we = 1'b0; host_pkt = '0;
        host_addr = '0; host_wdata = '0; host_rd_pkt = '0; host_rd_addr = '0;
        out_ready = 1'b1; cq_pop = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        chk("R9 reset done low", int'(done), 0);
        chk("R6 reset out_valid low", int'(out_valid), 0);
        chk("R8 reset completion queue empty", int'(cq_count), 0);

        // R1: enabled but empty queue
        tx_en = 1'b1;
        repeat (20) tick();
        chk("R1 empty queue no bytes", got_d.size(), 0);
        chk("R1 empty queue no done", done_seen, 0);

        // R1: queued but disabled
        tx_en = 1'b0;
        load(0, 16, 8'h00);
        load(1, 13, 8'h20);
        load(2, 11, 8'hDF);
        push(0); push(1); push(2);
        repeat (20) tick();
        chk("R1 disabled no bytes", got_d.size(), 0);
        chk("R1 disabled no done", done_seen, 0);

        // R3 R4 R9: three frames, random backpressure, no pad, logged
        ready_rand = 1'b1;
        add_exp(0, 0, 0); add_exp(1, 0, 0); add_exp(2, 0, 0);
        tx_en = 1'b1;
        drain("R3 R4 R9 in-order drain");
        check_status(0); check_status(1); check_status(2);
        check_cq("R8 logged order");

        // R5 R7: padding on, auto release
        tx_en = 1'b0; pad_en = 1'b1; auto_rel = 1'b1;
        load(3, 26, 8'h20);
        load(0, 76, 8'h10);
        push(3); push(0);
        add_exp(3, 1, 1); add_exp(0, 1, 1);
        tx_en = 1'b1;
        drain("R5 R7 pad and release");
        chk("R7 completion queue untouched", int'(cq_count), 0);
        check_status(3);

        // R11: zero-length and single odd byte
        tx_en = 1'b0; pad_en = 1'b0; auto_rel = 1'b0; ready_rand = 1'b0;
        load(1, 6, 8'h00);
        load(2, 6, 8'h20);
        push(1); push(2);
        add_exp(1, 0, 0); add_exp(2, 0, 0);
        tx_en = 1'b1;
        drain("R11 zero and one byte");
        check_cq("R11 logged");

        // R10: full queue and push during drain are dropped
        tx_en = 1'b0; ready_rand = 1'b1;
        load(0, 20, 8'h00);
        load(1, 30, 8'h20);
        load(2, 9, 8'h20);
        load(3, 40, 8'h00);
        push(0); push(1); push(2); push(3); push(3);
        add_exp(0, 0, 0); add_exp(1, 0, 0); add_exp(2, 0, 0); add_exp(3, 0, 0);
        tx_en = 1'b1;
        while (got_d.size() == 0) tick();
        push(0);
        drain("R10 full and busy pushes dropped");
        repeat (20) tick();
        chk("R10 no frame from dropped push", got_d.size(), 0);
        chk("R10 no done from dropped push", done_seen, 0);
        done_seen = 0;

        // R8: completion queue full, further entries dropped
        tx_en = 1'b0;
        push(2); push(1);
        add_exp(2, 0, 0); add_exp(1, 0, 0);
        tx_en = 1'b1;
        drain("R8 completion queue full");
        check_cq("R8 full queue keeps oldest");

        chk("R6 backpressure exercised", stalls > 0 ? 1 : 0, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule